// File: doc/BRIEF.md
# Read/Write Batching Scheduler with Shared Direction Mode

This block holds one request queue per memory bank and, on demand, chooses the next command to issue for a bank. All banks share one direction mode, either read or write. A pick only considers requests of the current direction, so reads are served together and writes are served together across the whole device. This reduces how often the data bus has to turn around. Within a direction, a request that hits the bank's open row wins over older requests that miss it.

The surrounding controller supplies new requests (bank, direction, row, column) and reports which row, if any, each bank has open. It asks for a pick by naming a bank. One cycle later the block returns the command: a column read or write for a row hit, which also removes the request; otherwise an activate or precharge that prepares the bank, leaving the request queued. A read that would overtake an older write to the same row and column turns the mode to write. When the current direction has no eligible request, the block looks at the other banks and then at the other direction. DRAM timing and refresh are not handled here.

Top module: `rwg_sched`

## Requirements
- R1: After a synchronous active-low reset the mode is read (`mode_write`=0), `pick_valid` is 0, `pick_cmd` is NOP (0) and every queue is empty.
- R2: When a pick is requested in read mode with no read pending in any bank, the pick runs in write mode. When a pick is requested in write mode with no write pending anywhere, it runs in read mode.
- R3: Within the direction in use, the oldest request whose row equals its bank's open row is picked. If there is no such request, the oldest request of that direction is picked. `pick_row` and `pick_col` give the picked request's row and column.
- R4: Command codes: NOP=0, ACT=1, PRE=2, RD=3, WR=4. A row hit gives RD or WR and removes the request. A miss on a closed bank gives ACT. A miss on a bank with another row open gives PRE. A miss leaves its request queued.
- R5: If the chosen read has an older write to the same row and column in its bank queue, the pick is redone in write mode.
- R6: If the requested bank has no eligible request, banks are searched in the order bank+1, bank+2, … (wrapping). If none is found, the other direction is searched once in the same order. If nothing is found at all, the command is NOP. `pick_bank` names the bank picked.
- R7: After a pick, `mode_write` shows the direction that produced it. Without a pick request the mode does not change.
- R8: Each queue holds QUEUE_DEPTH requests, and `bank_full` flags a full bank. An enqueue to a bank that is full at that edge is ignored, even if a request leaves the bank in the same cycle.
- R9: `pick_valid` and the pick fields appear in the cycle after `sched_req`. With no request, `pick_valid` is 0 and `pick_cmd` is NOP.
- R10: An enqueue and a removal on the same bank in the same cycle both take effect, and queue age order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enq_valid | input | 1 | New request present |
| enq_bank | input | BANK_W | Target bank of new request |
| enq_write | input | 1 | 1 = write request, 0 = read |
| enq_row | input | ROW_W | Row of new request |
| enq_col | input | COL_W | Column of new request |
| bank_open | input | NUM_BANKS | Per-bank open-row flag |
| bank_row | input | NUM_BANKS*ROW_W | Per-bank open row, bank 0 in the low bits |
| sched_req | input | 1 | Ask for a pick this cycle |
| sched_bank | input | BANK_W | Bank the pick starts from |
| mode_write | output | 1 | Shared mode, 1 = write |
| bank_full | output | NUM_BANKS | Per-bank queue full |
| pick_valid | output | 1 | Pick result present |
| pick_cmd | output | 3 | Command code |
| pick_bank | output | BANK_W | Bank of the picked request |
| pick_row | output | ROW_W | Row of the picked request |
| pick_col | output | COL_W | Column of the picked request |

## Verification
Several rules are checked on every cycle by the assertions. The mode holds between picks, and a pick result follows each request by exactly one cycle. A column command always matches the reported mode. A NOP is never returned while any request is pending, and the counters and queues never underflow or overflow. Other behaviour can only be shown by scenarios that compare results against a bench model of the queues. This covers the choice between hit and oldest, the order of the bank rotation, hazard redirection, mode flips when a direction drains, dropped enqueues to a full bank, and same-cycle enqueue with removal.

// File: rtl/rwg_pkg.sv
// Shared command encoding for the read/write batching scheduler.
package rwg_pkg;
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_PRE = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4
    } rwg_cmd_e;
endpackage

// File: rtl/rwg_bank_queue.sv
// Age-ordered request queue for one bank. Slot 0 is the oldest entry.
// Removal at any slot compacts younger entries downward. An enqueue is
// accepted only if the queue was not full at the start of the cycle.
// Assumes deq_slot names a valid entry whenever deq is high.
module rwg_bank_queue #(
    parameter int DEPTH = 4,
    parameter int ROW_W = 8,
    parameter int COL_W = 6,
    localparam int SLOT_W = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enq,
    input  logic                     enq_write,
    input  logic [ROW_W-1:0]         enq_row,
    input  logic [COL_W-1:0]         enq_col,
    input  logic                     deq,
    input  logic [SLOT_W-1:0]        deq_slot,
    output logic [DEPTH-1:0]         vld,
    output logic [DEPTH-1:0]         wr,
    output logic [DEPTH*ROW_W-1:0]   rows,
    output logic [DEPTH*COL_W-1:0]   cols,
    output logic                     full
);
    logic [CNT_W-1:0] cnt_q, cnt_mid, cnt_n;
    logic             wr_q  [DEPTH];
    logic [ROW_W-1:0] row_q [DEPTH];
    logic [COL_W-1:0] col_q [DEPTH];
    logic             wr_n  [DEPTH];
    logic [ROW_W-1:0] row_n [DEPTH];
    logic [COL_W-1:0] col_n [DEPTH];
    logic             accept;

    // Flatten the stored entries for the pick logic.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            vld[i] = CNT_W'(i) < cnt_q;
            wr[i]  = wr_q[i];
            rows[i*ROW_W +: ROW_W] = row_q[i];
            cols[i*COL_W +: COL_W] = col_q[i];
        end
        full = (cnt_q == CNT_W'(DEPTH));
    end

    // Compact on removal, then append an accepted request behind the survivors.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (deq && (SLOT_W'(i) >= deq_slot) && (i < DEPTH - 1)) begin
                wr_n[i]  = wr_q[i+1];
                row_n[i] = row_q[i+1];
                col_n[i] = col_q[i+1];
            end else begin
                wr_n[i]  = wr_q[i];
                row_n[i] = row_q[i];
                col_n[i] = col_q[i];
            end
        end
        accept  = enq && !full;
        cnt_mid = cnt_q - CNT_W'(deq);
        if (accept) begin
            wr_n[cnt_mid[SLOT_W-1:0]]  = enq_write;
            row_n[cnt_mid[SLOT_W-1:0]] = enq_row;
            col_n[cnt_mid[SLOT_W-1:0]] = enq_col;
        end
        cnt_n = cnt_mid + CNT_W'(accept);
    end

    // Register the queue contents and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                wr_q[i]  <= 1'b0;
                row_q[i] <= '0;
                col_q[i] <= '0;
            end
        end else begin
            cnt_q <= cnt_n;
            for (int i = 0; i < DEPTH; i++) begin
                wr_q[i]  <= wr_n[i];
                row_q[i] <= row_n[i];
                col_q[i] <= col_n[i];
            end
        end
    end

    p_occupancy_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));
    p_deq_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        deq |-> (CNT_W'(deq_slot) < cnt_q));
endmodule

// File: rtl/rwg_bank_pick.sv
// Combinational selector for one bank and one direction. It returns the
// oldest request of the wanted direction that hits the open row, or else
// the oldest request of that direction. Assumes vld is contiguous from slot 0.
module rwg_bank_pick #(
    parameter int DEPTH = 4,
    parameter int ROW_W = 8,
    localparam int SLOT_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]       vld,
    input  logic [DEPTH-1:0]       wr,
    input  logic [DEPTH*ROW_W-1:0] rows,
    input  logic                   want_write,
    input  logic                   is_open,
    input  logic [ROW_W-1:0]       open_row,
    output logic                   found,
    output logic                   hit,
    output logic [SLOT_W-1:0]      slot
);
    logic [SLOT_W-1:0] any_s, hit_s;

    // Scan from youngest to oldest so the oldest match is the one kept.
    always_comb begin
        found = 1'b0;
        hit   = 1'b0;
        any_s = '0;
        hit_s = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vld[i] && (wr[i] == want_write)) begin
                found = 1'b1;
                any_s = SLOT_W'(i);
                if (is_open && (rows[i*ROW_W +: ROW_W] == open_row)) begin
                    hit   = 1'b1;
                    hit_s = SLOT_W'(i);
                end
            end
        end
        slot = hit ? hit_s : any_s;
    end
endmodule

// File: rtl/rwg_hazard.sv
// Flags a read candidate that has an older write to the same row and
// column in the same queue. Assumes slot names the read candidate.
module rwg_hazard #(
    parameter int DEPTH = 4,
    parameter int ROW_W = 8,
    parameter int COL_W = 6,
    localparam int SLOT_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]       vld,
    input  logic [DEPTH-1:0]       wr,
    input  logic [DEPTH*ROW_W-1:0] rows,
    input  logic [DEPTH*COL_W-1:0] cols,
    input  logic [SLOT_W-1:0]      slot,
    output logic                   hazard
);
    // Compare every older write against the candidate's address.
    always_comb begin
        hazard = 1'b0;
        for (int j = 0; j < DEPTH; j++) begin
            if (vld[j] && wr[j] && (SLOT_W'(j) < slot) &&
                (rows[j*ROW_W +: ROW_W] == rows[slot*ROW_W +: ROW_W]) &&
                (cols[j*COL_W +: COL_W] == cols[slot*COL_W +: COL_W]))
                hazard = 1'b1;
        end
    end
endmodule

// File: rtl/rwg_tally.sv
// Device-wide counts of pending reads and writes, kept up to date on each
// accepted enqueue and each removal rather than found by scanning the queues.
module rwg_tally #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_rd,
    input  logic             inc_wr,
    input  logic             dec_rd,
    input  logic             dec_wr,
    output logic [CNT_W-1:0] rd_cnt,
    output logic [CNT_W-1:0] wr_cnt
);
    // Apply the signed change of this cycle to each count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt <= '0;
            wr_cnt <= '0;
        end else begin
            rd_cnt <= rd_cnt + CNT_W'(inc_rd) - CNT_W'(dec_rd);
            wr_cnt <= wr_cnt + CNT_W'(inc_wr) - CNT_W'(dec_wr);
        end
    end

    p_rd_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_rd |-> (rd_cnt != '0));
    p_wr_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_wr |-> (wr_cnt != '0));
endmodule

// File: rtl/rwg_sched.sv
// Read/write batching scheduler. It keeps per-bank request queues and one
// direction mode shared by all banks. On sched_req it works out the mode to
// use, searches banks in rotation from sched_bank, redirects on a
// read-after-write hazard or an empty direction, and registers the command.
// Assumes NUM_BANKS is a power of two (at least 2) and QUEUE_DEPTH >= 2.
module rwg_sched #(
    parameter int NUM_BANKS   = 4,
    parameter int QUEUE_DEPTH = 4,
    parameter int ROW_W       = 8,
    parameter int COL_W       = 6,
    localparam int BANK_W  = $clog2(NUM_BANKS),
    localparam int SLOT_W  = $clog2(QUEUE_DEPTH),
    localparam int TOTAL_W = $clog2(NUM_BANKS * QUEUE_DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enq_valid,
    input  logic [BANK_W-1:0]          enq_bank,
    input  logic                       enq_write,
    input  logic [ROW_W-1:0]           enq_row,
    input  logic [COL_W-1:0]           enq_col,
    input  logic [NUM_BANKS-1:0]       bank_open,
    input  logic [NUM_BANKS*ROW_W-1:0] bank_row,
    input  logic                       sched_req,
    input  logic [BANK_W-1:0]          sched_bank,
    output logic                       mode_write,
    output logic [NUM_BANKS-1:0]       bank_full,
    output logic                       pick_valid,
    output logic [2:0]                 pick_cmd,
    output logic [BANK_W-1:0]          pick_bank,
    output logic [ROW_W-1:0]           pick_row,
    output logic [COL_W-1:0]           pick_col
);
    import rwg_pkg::*;

    logic [QUEUE_DEPTH-1:0]       q_vld  [NUM_BANKS];
    logic [QUEUE_DEPTH-1:0]       q_wr   [NUM_BANKS];
    logic [QUEUE_DEPTH*ROW_W-1:0] q_rows [NUM_BANKS];
    logic [QUEUE_DEPTH*COL_W-1:0] q_cols [NUM_BANKS];
    logic [NUM_BANKS-1:0]         rd_found, rd_hit, wr_found, wr_hit, rd_haz;
    logic [SLOT_W-1:0]            rd_slot [NUM_BANKS];
    logic [SLOT_W-1:0]            wr_slot [NUM_BANKS];
    logic [TOTAL_W-1:0]           rd_cnt, wr_cnt;

    logic              mode_q, mode_eff, p1_found, p2_found, p2_mode, haz1, use_p2;
    logic [BANK_W-1:0] p1_bank, p2_bank;
    logic              fin_mode, fin_found, fin_hit, deq_en, enq_acc;
    logic [BANK_W-1:0] fin_bank;
    logic [SLOT_W-1:0] fin_slot;
    rwg_cmd_e          fin_cmd;

    assign enq_acc = enq_valid && !bank_full[enq_bank];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        rwg_bank_queue #(.DEPTH(QUEUE_DEPTH), .ROW_W(ROW_W), .COL_W(COL_W)) u_queue (
            .clk(clk), .rst_n(rst_n),
            .enq(enq_valid && (enq_bank == BANK_W'(b))),
            .enq_write(enq_write), .enq_row(enq_row), .enq_col(enq_col),
            .deq(deq_en && (fin_bank == BANK_W'(b))), .deq_slot(fin_slot),
            .vld(q_vld[b]), .wr(q_wr[b]), .rows(q_rows[b]), .cols(q_cols[b]),
            .full(bank_full[b]));
        rwg_bank_pick #(.DEPTH(QUEUE_DEPTH), .ROW_W(ROW_W)) u_pick_rd (
            .vld(q_vld[b]), .wr(q_wr[b]), .rows(q_rows[b]), .want_write(1'b0),
            .is_open(bank_open[b]), .open_row(bank_row[b*ROW_W +: ROW_W]),
            .found(rd_found[b]), .hit(rd_hit[b]), .slot(rd_slot[b]));
        rwg_bank_pick #(.DEPTH(QUEUE_DEPTH), .ROW_W(ROW_W)) u_pick_wr (
            .vld(q_vld[b]), .wr(q_wr[b]), .rows(q_rows[b]), .want_write(1'b1),
            .is_open(bank_open[b]), .open_row(bank_row[b*ROW_W +: ROW_W]),
            .found(wr_found[b]), .hit(wr_hit[b]), .slot(wr_slot[b]));
        rwg_hazard #(.DEPTH(QUEUE_DEPTH), .ROW_W(ROW_W), .COL_W(COL_W)) u_hazard (
            .vld(q_vld[b]), .wr(q_wr[b]), .rows(q_rows[b]), .cols(q_cols[b]),
            .slot(rd_slot[b]), .hazard(rd_haz[b]));
    end

    rwg_tally #(.CNT_W(TOTAL_W)) u_tally (
        .clk(clk), .rst_n(rst_n),
        .inc_rd(enq_acc && !enq_write), .inc_wr(enq_acc && enq_write),
        .dec_rd(deq_en && !fin_mode), .dec_wr(deq_en && fin_mode),
        .rd_cnt(rd_cnt), .wr_cnt(wr_cnt));

    // Rotating bank search for one direction; returns {found, bank}.
    function automatic logic [BANK_W:0] scan(input logic want_w);
        logic [BANK_W-1:0] idx;
        scan = '0;
        for (int k = 0; k < NUM_BANKS; k++) begin
            idx = sched_bank + BANK_W'(k);
            if (!scan[BANK_W] && (want_w ? wr_found[idx] : rd_found[idx]))
                scan = {1'b1, idx};
        end
    endfunction

    // Choose the mode, run up to two search passes and form the command.
    always_comb begin
        mode_eff = mode_q;
        if (!mode_q && (rd_cnt == '0))      mode_eff = 1'b1;
        else if (mode_q && (wr_cnt == '0))  mode_eff = 1'b0;
        {p1_found, p1_bank} = scan(mode_eff);
        haz1    = p1_found && !mode_eff && rd_haz[p1_bank];
        p2_mode = haz1 ? 1'b1 : !mode_eff;
        {p2_found, p2_bank} = scan(p2_mode);
        use_p2    = haz1 || !p1_found;
        fin_mode  = use_p2 ? p2_mode  : mode_eff;
        fin_found = use_p2 ? p2_found : p1_found;
        fin_bank  = use_p2 ? p2_bank  : p1_bank;
        fin_slot  = fin_mode ? wr_slot[fin_bank] : rd_slot[fin_bank];
        fin_hit   = fin_mode ? wr_hit[fin_bank]  : rd_hit[fin_bank];
        if (!fin_found)          fin_cmd = CMD_NOP;
        else if (fin_hit)        fin_cmd = fin_mode ? CMD_WR : CMD_RD;
        else if (bank_open[fin_bank]) fin_cmd = CMD_PRE;
        else                     fin_cmd = CMD_ACT;
        deq_en = sched_req && fin_found && fin_hit;
    end

    // Register the mode and the pick result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= 1'b0;
            pick_valid <= 1'b0;
            pick_cmd   <= CMD_NOP;
            pick_bank  <= '0;
            pick_row   <= '0;
            pick_col   <= '0;
        end else begin
            pick_valid <= sched_req;
            pick_cmd   <= sched_req ? fin_cmd : CMD_NOP;
            if (sched_req) begin
                mode_q    <= fin_mode;
                pick_bank <= fin_bank;
                pick_row  <= q_rows[fin_bank][fin_slot*ROW_W +: ROW_W];
                pick_col  <= q_cols[fin_bank][fin_slot*COL_W +: COL_W];
            end
        end
    end

    assign mode_write = mode_q;

    p_mode_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sched_req |=> $stable(mode_q));
    p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sched_req |=> pick_valid);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sched_req |=> (!pick_valid && pick_cmd == CMD_NOP));
    p_rd_in_read_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_valid && pick_cmd == CMD_RD) |-> !mode_q);
    p_wr_in_write_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_valid && pick_cmd == CMD_WR) |-> mode_q);
    p_no_nop_when_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_req && (rd_cnt != '0 || wr_cnt != '0)) |=> (pick_cmd != CMD_NOP));
    p_hazard_to_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_req && haz1) |=> mode_q);
endmodule

// File: tb/tb_rwg_sched.sv
module tb_rwg_sched;
    localparam int NB = 4, QD = 4;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        enq_valid = 1'b0, enq_write = 1'b0, sched_req = 1'b0;
    logic [1:0]  enq_bank = '0, sched_bank = '0;
    logic [7:0]  enq_row = '0;
    logic [5:0]  enq_col = '0;
    logic [3:0]  bank_open = '0;
    logic [31:0] bank_row = '0;
    logic        mode_write, pick_valid;
    logic [3:0]  bank_full;
    logic [2:0]  pick_cmd;
    logic [1:0]  pick_bank;
    logic [7:0]  pick_row;
    logic [5:0]  pick_col;

    rwg_sched dut (.clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_bank(enq_bank),
        .enq_write(enq_write), .enq_row(enq_row), .enq_col(enq_col),
        .bank_open(bank_open), .bank_row(bank_row), .sched_req(sched_req),
        .sched_bank(sched_bank), .mode_write(mode_write), .bank_full(bank_full),
        .pick_valid(pick_valid), .pick_cmd(pick_cmd), .pick_bank(pick_bank),
        .pick_row(pick_row), .pick_col(pick_col));

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int m_n[NB];
    bit m_w[NB][QD];
    int m_r[NB][QD], m_c[NB][QD];
    bit m_mode;
    bit op[NB];
    int orow[NB];
    bit pend, e_valid, e_mode;
    int e_cmd, e_bank, e_row, e_col;
    bit [3:0] e_full;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic void mfind(int b, bit want, output bit f, output int s, output bit h);
        int hs = 0;
        f = 0; h = 0; s = 0;
        for (int i = 0; i < m_n[b]; i++) begin
            if (m_w[b][i] == want) begin
                if (!f) begin f = 1; s = i; end
                if (op[b] && m_r[b][i] == orow[b] && !h) begin h = 1; hs = i; end
            end
        end
        if (h) s = hs;
    endfunction

    function automatic void mscan(bit want, int rb, output bit f, output int bk);
        bit ff, hh; int ss;
        f = 0; bk = 0;
        for (int k = 0; k < NB; k++) begin
            mfind((rb + k) % NB, want, ff, ss, hh);
            if (ff && !f) begin f = 1; bk = (rb + k) % NB; end
        end
    endfunction

    function automatic bit mhaz(int b, int s);
        for (int j = 0; j < s; j++)
            if (m_w[b][j] && m_r[b][j] == m_r[b][s] && m_c[b][j] == m_c[b][s]) return 1;
        return 0;
    endfunction

    // Reference behaviour built from the requirements (R2..R10).
    task automatic model(bit en, int eb, bit ew, int er, int ec, bit rq, int rb);
        bit full_before, me, f1, f2, fm, ff, hh; int b1, b2, fb, s, nr, nw;
        full_before = (m_n[eb] == QD);
        e_valid = rq; e_cmd = 0;
        if (rq) begin
            nr = 0; nw = 0;
            for (int b = 0; b < NB; b++)
                for (int i = 0; i < m_n[b]; i++) if (m_w[b][i]) nw++; else nr++;
            me = m_mode;
            if (!me && nr == 0) me = 1; else if (me && nw == 0) me = 0;
            mscan(me, rb, f1, b1);
            fm = me; ff = f1; fb = b1;
            if (f1 && !me) begin
                mfind(b1, 0, ff, s, hh);
                if (mhaz(b1, s)) begin fm = 1; mscan(1, rb, ff, fb); end
            end else if (!f1) begin
                fm = !me; mscan(fm, rb, ff, fb);
            end
            m_mode = fm; e_mode = fm;
            if (ff) begin
                mfind(fb, fm, ff, s, hh);
                e_bank = fb; e_row = m_r[fb][s]; e_col = m_c[fb][s];
                e_cmd = hh ? (fm ? 4 : 3) : (op[fb] ? 2 : 1);
                if (hh) begin
                    for (int i = s; i < m_n[fb] - 1; i++) begin
                        m_w[fb][i] = m_w[fb][i+1]; m_r[fb][i] = m_r[fb][i+1];
                        m_c[fb][i] = m_c[fb][i+1];
                    end
                    m_n[fb]--;
                end
            end
        end
        if (en && !full_before) begin
            m_w[eb][m_n[eb]] = ew; m_r[eb][m_n[eb]] = er; m_c[eb][m_n[eb]] = ec;
            m_n[eb]++;
        end
        e_mode = m_mode;
        for (int b = 0; b < NB; b++) e_full[b] = (m_n[b] == QD);
    endtask

    task automatic compare_pending();
        if (pend) begin
            chk("R7 mode", mode_write, e_mode);
            chk("R9 pick_valid", pick_valid, e_valid);
            chk("R4 pick_cmd", pick_cmd, e_cmd);
            chk("R8 bank_full", bank_full, e_full);
            if (e_valid && e_cmd != 0) begin
                chk("R6 pick_bank", pick_bank, e_bank);
                chk("R3 pick_row", pick_row, e_row);
                chk("R3 pick_col", pick_col, e_col);
            end
        end
    endtask

    task automatic step(bit en, int eb, bit ew, int er, int ec, bit rq, int rb);
        @(negedge clk);
        compare_pending();
        enq_valid = en; enq_bank = 2'(eb); enq_write = ew;
        enq_row = 8'(er); enq_col = 6'(ec);
        sched_req = rq; sched_bank = 2'(rb);
        for (int b = 0; b < NB; b++) begin
            bank_open[b] = op[b]; bank_row[b*8 +: 8] = 8'(orow[b]);
        end
        model(en, eb, ew, er, ec, rq, rb);
        pend = 1;
    endtask

    task automatic after_edge();
        @(posedge clk); #1;
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit dummy;
        dummy = 0;
        void'($urandom(32'd4242));
        for (int b = 0; b < NB; b++) begin m_n[b] = 0; op[b] = 0; orow[b] = 0; end
        m_mode = 0; pend = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset mode", mode_write, 0);
        chk("R1 reset pick_valid", pick_valid, 0);
        chk("R1 reset pick_cmd", pick_cmd, 0);
        chk("R1 reset bank_full", bank_full, 0);
        @(negedge clk); rst_n = 1;

        // R5 hazard, then R2 drain flip back to read.
        op[0] = 1; orow[0] = 1;
        step(1, 0, 1, 1, 1, 0, 0);
        step(1, 0, 0, 1, 1, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0); after_edge();
        chk("R5 hazard redirects to WR", pick_cmd, 4);
        chk("R5 mode forced to write", mode_write, 1);
        step(0, 0, 0, 0, 0, 1, 0); after_edge();
        chk("R2 writes drained, RD picked", pick_cmd, 3);
        chk("R2 mode back to read", mode_write, 0);

        // R8 full bank drops the extra enqueue.
        op[3] = 1; orow[3] = 5;
        for (int i = 0; i < 5; i++) begin
            step(1, 3, 1, 5, i, 0, 0);
            if (i == 3) begin after_edge(); chk("R8 bank 3 full", bank_full[3], 1); end
        end
        for (int i = 0; i < 5; i++) begin
            step(0, 0, 0, 0, 0, 1, 3); after_edge();
            chk("R8 only QUEUE_DEPTH writes served", pick_cmd, (i < 4) ? 4 : 0);
        end

        // R6 rotation to another bank; R4 ACT, PRE, then RD.
        op[2] = 0; orow[2] = 0;
        step(1, 2, 0, 7, 0, 0, 0);
        step(0, 0, 0, 0, 0, 1, 0); after_edge();
        chk("R6 rotation finds bank 2", pick_bank, 2);
        chk("R4 closed bank gives ACT", pick_cmd, 1);
        op[2] = 1; orow[2] = 9;
        step(0, 0, 0, 0, 0, 1, 2); after_edge();
        chk("R4 other row open gives PRE", pick_cmd, 2);
        orow[2] = 7;
        step(0, 0, 0, 0, 0, 1, 2); after_edge();
        chk("R4 hit gives RD", pick_cmd, 3);

        // R10 enqueue and removal on one bank in one cycle.
        op[1] = 1; orow[1] = 2;
        step(1, 1, 0, 2, 0, 0, 0);
        step(1, 1, 0, 2, 3, 1, 1); after_edge();
        chk("R10 first read served", pick_col, 0);
        step(0, 0, 0, 0, 0, 1, 1); after_edge();
        chk("R10 same-cycle enqueue kept", pick_col, 3);
        chk("R10 same-cycle enqueue cmd", pick_cmd, 3);

        // Constrained random traffic checked against the model.
        for (int c = 0; c < 4000; c++) begin
            for (int b = 0; b < NB; b++) begin
                op[b] = ($urandom % 4) != 0; orow[b] = $urandom % 4;
            end
            step(($urandom % 2) == 1, $urandom % NB, ($urandom % 2) == 1,
                 $urandom % 4, $urandom % 4, ($urandom % 2) == 1, $urandom % NB);
        end
        step(0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare_pending();
        if (dummy) $display("unused");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule